// File: doc/BRIEF.md
# Time Snapshot Controller with Change Flags

This block sits between a free-running calendar counter and a small bank of host-visible registers. On a snapshot command it freezes the eight live time and date fields into registers 2 to 9. At the same moment it sets one flag per field in register 1 for each field whose value differs from the previous snapshot. Software can then read only the fields that moved. On a load command it hands registers 2 to 9 back to the counter as a new time, together with a one-cycle request, and clears the flags. A lock bit in the status register at address 0 can veto the load.

The status register also holds a frequency-measurement enable and two test-mode bits. While measurement is enabled and the host is not selecting the device, a square wave derived from a parameterised divider is driven out (about 256 Hz at the default setting on a 50 MHz clock). The live counter never stalls for host access: the host only ever sees the frozen copy.

Field i of every flat bus occupies bits [8i+7:8i]. Field 0 is seconds, then minutes, hours, day of month, month, year, weekday, and field 7 is week number. Field i maps to register address 2+i.

Top module: `tsnap_ctrl`

## Requirements
- R1: One cycle after `cmd_snap`, each field i of `snap_regs` equals field i of `live_time` as sampled at the command edge.
- R2: The same snapshot sets `flag_reg` bit i to 1 exactly when live field i differs from the value captured by the previous snapshot (all zero after reset). Host writes to registers 2-9 do not change this comparison.
- R3: A `cmd_load` with the lock bit clear (and no `cmd_snap` in the same cycle) makes `load_req` high for exactly the next cycle. In that cycle `load_time` carries `snap_regs` as they stood at the command, and `flag_reg` reads 0.
- R4: While status bit 4 (lock) is 1, `cmd_load` is ignored: `load_req` stays 0 and `flag_reg` and `load_time` are unchanged. Writing bit 4 back to 0 re-enables the load.
- R5: `flag_reg` is read-only. A write to address 1 changes nothing, and the flags change only on a snapshot or an accepted load.
- R6: A write to address 0 stores data bits 0 (measure enable), 2 and 3 (test modes) and 4 (lock) into `stat_reg` on the next cycle. Bits 1, 5, 6 and 7 always read 0.
- R7: A write to address 2+i (i = 0..7) sets field i of `snap_regs` on the next cycle. Writes to addresses 10 to 15 have no effect, and a snapshot in the same cycle as a field write takes priority.
- R8: `meas_out` equals an internal phase whenever status bit 0 is 1 and `host_sel_n` is 1, and is 0 otherwise. The phase is 0 after reset and inverts after every `HALF_CYC` clock cycles.
- R9: Synchronous active-low reset clears `stat_reg`, `flag_reg`, `snap_regs`, `load_time`, `load_req`, the previous-snapshot copy and the measurement phase.
- R10: Without a snapshot or a field write, `snap_regs` hold their value while `live_time` keeps changing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_snap | input | 1 | Snapshot command pulse (copy live time to registers) |
| cmd_load | input | 1 | Load command pulse (copy registers to live time) |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 4 | Host register address |
| wr_data | input | 8 | Host write data |
| live_time | input | 64 | Live calendar fields, field i at [8i+7:8i] |
| host_sel_n | input | 1 | Host select, active low; high enables measurement output |
| stat_reg | output | 8 | Status register (address 0) |
| flag_reg | output | 8 | Change-flag register (address 1) |
| snap_regs | output | 64 | Snapshot registers 2-9, field i at [8i+7:8i] |
| load_req | output | 1 | One-cycle request to load `load_time` into the counter |
| load_time | output | 64 | Time and date to be loaded |
| meas_out | output | 1 | Frequency-measurement square wave |

## Verification
A corrupted previous-snapshot copy does not show at once. It shows only at the next snapshot, as wrong bits in `flag_reg` one cycle after the command. The bench therefore takes repeated snapshots both with the live fields unchanged and with them changed, and interleaves host writes to the frozen fields. A wrong lock or status bit shows within one cycle of the next load or status write, as a stray or missing `load_req` or a mismatch in `stat_reg`. A divider off by one shows as `meas_out` flipping on the wrong cycle, within one half period. The bench compares every output against its own model on every clock, so each of these appears at its first observable cycle.

// File: rtl/tsnap_pkg.sv
// Shared constants for the time snapshot controller: register addresses,
// status bit positions and the writable-bit mask of the status register.
package tsnap_pkg;
    localparam int ADDR_STAT       = 0;
    localparam int ADDR_FLAG       = 1;
    localparam int ADDR_FIRST_FLD  = 2;

    localparam int BIT_MEAS        = 0;
    localparam int BIT_TEST0       = 2;
    localparam int BIT_TEST1       = 3;
    localparam int BIT_LOCK        = 4;

    localparam int STAT_W          = 8;
    localparam logic [STAT_W-1:0] STAT_WR_MASK =
        STAT_W'((1 << BIT_MEAS) | (1 << BIT_TEST0) | (1 << BIT_TEST1) | (1 << BIT_LOCK));
endpackage

// File: rtl/tsnap_status.sv
// Status register at address 0.
// Stores only the measurement enable, the two test-mode bits and the lock bit;
// reserved bits are masked on write and therefore always read as zero.
// Assumes wr_data is at least STAT_W bits wide.
module tsnap_status
    import tsnap_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [STAT_W-1:0] stat_o,
    output logic              lock_o,
    output logic              meas_en_o
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ADDR_STAT);

    logic [STAT_W-1:0] stat_q;

    // Purpose: capture host writes to the status address, masking reserved bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (wr_en && (wr_addr == MY_ADDR)) begin
            stat_q <= wr_data[STAT_W-1:0] & STAT_WR_MASK;
        end
    end

    assign stat_o    = stat_q;
    assign lock_o    = stat_q[BIT_LOCK];
    assign meas_en_o = stat_q[BIT_MEAS];
endmodule

// File: rtl/tsnap_capture.sv
// Snapshot bank, previous-snapshot shadow, change flags and load path.
// One slice per field is generated. do_snap and do_load are already
// arbitrated by the parent and are never high together.
// Assumes BASE_ADDR + NUM_FIELDS <= 2**ADDR_W.
module tsnap_capture #(
    parameter int FIELD_W    = 8,
    parameter int NUM_FIELDS = 8,
    parameter int ADDR_W     = 4,
    parameter int BASE_ADDR  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          do_snap,
    input  logic                          do_load,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [FIELD_W-1:0]            wr_data,
    input  logic [FIELD_W*NUM_FIELDS-1:0] live_flat,
    output logic [FIELD_W*NUM_FIELDS-1:0] snap_flat,
    output logic [NUM_FIELDS-1:0]         flags_o,
    output logic                          load_req_o,
    output logic [FIELD_W*NUM_FIELDS-1:0] load_flat
);
    logic load_req_q;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
        localparam logic [ADDR_W-1:0] FLD_ADDR = ADDR_W'(BASE_ADDR + g);

        logic [FIELD_W-1:0] live_f;
        logic [FIELD_W-1:0] snap_q;
        logic [FIELD_W-1:0] shadow_q;
        logic [FIELD_W-1:0] load_q;
        logic               flag_q;
        logic               hit;

        assign live_f = live_flat[g*FIELD_W +: FIELD_W];
        assign hit    = wr_en && (wr_addr == FLD_ADDR);

        // Purpose: host-visible frozen field; snapshot wins over a host write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                snap_q <= '0;
            end else if (do_snap) begin
                snap_q <= live_f;
            end else if (hit) begin
                snap_q <= wr_data;
            end
        end

        // Purpose: private copy of the last snapshot, untouched by host writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q <= '0;
            end else if (do_snap) begin
                shadow_q <= live_f;
            end
        end

        // Purpose: change flag, set by compare on snapshot, cleared by load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (do_snap) begin
                flag_q <= (live_f != shadow_q);
            end else if (do_load) begin
                flag_q <= 1'b0;
            end
        end

        // Purpose: hold the value handed to the live counter on a load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                load_q <= '0;
            end else if (do_load) begin
                load_q <= snap_q;
            end
        end

        assign snap_flat[g*FIELD_W +: FIELD_W] = snap_q;
        assign load_flat[g*FIELD_W +: FIELD_W] = load_q;
        assign flags_o[g]                      = flag_q;
    end

    // Purpose: one-cycle load request following an accepted load command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_req_q <= 1'b0;
        end else begin
            load_req_q <= do_load;
        end
    end

    assign load_req_o = load_req_q;
endmodule

// File: rtl/tsnap_meas.sv
// Frequency-measurement divider: a phase bit that inverts every HALF_CYC
// clocks, gated onto the output only while enabled and the host is not
// selecting the block. The divider runs continuously so enabling it does
// not restart the wave.
module tsnap_meas #(
    parameter int HALF_CYC = 97656
) (
    input  logic clk,
    input  logic rst_n,
    input  logic meas_en,
    input  logic sel_n,
    output logic meas_o
);
    localparam int CNT_W = $clog2(HALF_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;

    // Purpose: count clocks within a half period and flip the phase at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign meas_o = meas_en && sel_n && phase_q;
endmodule

// File: rtl/tsnap_ctrl.sv
// Top of the time snapshot controller. It arbitrates the two commands
// (snapshot has priority; load needs the lock bit clear) and wires the
// status register, the snapshot bank and the measurement divider together.
// Assumes commands are single-cycle pulses synchronous to clk.
module tsnap_ctrl
    import tsnap_pkg::*;
#(
    parameter int FIELD_W    = 8,
    parameter int NUM_FIELDS = 8,
    parameter int ADDR_W     = 4,
    parameter int HALF_CYC   = 97656
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_snap,
    input  logic                          cmd_load,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [FIELD_W-1:0]            wr_data,
    input  logic [FIELD_W*NUM_FIELDS-1:0] live_time,
    input  logic                          host_sel_n,
    output logic [STAT_W-1:0]             stat_reg,
    output logic [NUM_FIELDS-1:0]         flag_reg,
    output logic [FIELD_W*NUM_FIELDS-1:0] snap_regs,
    output logic                          load_req,
    output logic [FIELD_W*NUM_FIELDS-1:0] load_time,
    output logic                          meas_out
);
    logic lock;
    logic meas_en;
    logic load_go;

    // Purpose: accept a load only without a competing snapshot and when unlocked.
    always_comb begin
        load_go = cmd_load && !cmd_snap && !lock;
    end

    tsnap_status #(
        .ADDR_W (ADDR_W),
        .DATA_W (FIELD_W)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .stat_o    (stat_reg),
        .lock_o    (lock),
        .meas_en_o (meas_en)
    );

    tsnap_capture #(
        .FIELD_W    (FIELD_W),
        .NUM_FIELDS (NUM_FIELDS),
        .ADDR_W     (ADDR_W),
        .BASE_ADDR  (ADDR_FIRST_FLD)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_snap    (cmd_snap),
        .do_load    (load_go),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .live_flat  (live_time),
        .snap_flat  (snap_regs),
        .flags_o    (flag_reg),
        .load_req_o (load_req),
        .load_flat  (load_time)
    );

    tsnap_meas #(
        .HALF_CYC (HALF_CYC)
    ) u_meas (
        .clk     (clk),
        .rst_n   (rst_n),
        .meas_en (meas_en),
        .sel_n   (host_sel_n),
        .meas_o  (meas_out)
    );
endmodule

// File: rtl/tsnap_checker.sv
// Port-level properties of tsnap_ctrl, attached by bind below.
module tsnap_checker #(
    parameter int FIELD_W    = 8,
    parameter int NUM_FIELDS = 8,
    parameter int ADDR_W     = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cmd_snap,
    input logic                          cmd_load,
    input logic                          wr_en,
    input logic [FIELD_W*NUM_FIELDS-1:0] live_time,
    input logic                          host_sel_n,
    input logic [7:0]                    stat_reg,
    input logic [NUM_FIELDS-1:0]         flag_reg,
    input logic [FIELD_W*NUM_FIELDS-1:0] snap_regs,
    input logic                          load_req,
    input logic [FIELD_W*NUM_FIELDS-1:0] load_time,
    input logic                          meas_out
);
    a_r1_capture_live: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_snap |=> snap_regs == $past(live_time));

    a_r3_load_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && !cmd_snap && !stat_reg[4]) |=>
            (load_req && flag_reg == '0 && load_time == $past(snap_regs)));

    a_r4_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && stat_reg[4]) |=> !load_req);

    a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_snap && !cmd_load) |=> $stable(flag_reg));

    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_reg & 8'hE2) == 8'h00);

    a_r8_meas_gated: assert property (@(posedge clk) disable iff (!rst_n)
        meas_out |-> (host_sel_n && stat_reg[0]));

    a_r10_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_snap && !wr_en) |=> $stable(snap_regs));
endmodule

bind tsnap_ctrl tsnap_checker #(
    .FIELD_W    (FIELD_W),
    .NUM_FIELDS (NUM_FIELDS),
    .ADDR_W     (ADDR_W)
) u_tsnap_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_snap   (cmd_snap),
    .cmd_load   (cmd_load),
    .wr_en      (wr_en),
    .live_time  (live_time),
    .host_sel_n (host_sel_n),
    .stat_reg   (stat_reg),
    .flag_reg   (flag_reg),
    .snap_regs  (snap_regs),
    .load_req   (load_req),
    .load_time  (load_time),
    .meas_out   (meas_out)
);

// File: tb/tb_tsnap_ctrl.sv
module tb_tsnap_ctrl;
    localparam int FW   = 8;
    localparam int NF   = 8;
    localparam int AW   = 4;
    localparam int HALF = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_snap = 1'b0;
    logic              cmd_load = 1'b0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [FW-1:0]     wr_data = '0;
    logic [FW*NF-1:0]  live_time;
    logic              host_sel_n = 1'b0;
    logic [7:0]        stat_reg;
    logic [NF-1:0]     flag_reg;
    logic [FW*NF-1:0]  snap_regs;
    logic              load_req;
    logic [FW*NF-1:0]  load_time;
    logic              meas_out;

    logic [FW-1:0] live [NF];

    // reference model state
    logic [FW-1:0] m_snap [NF];
    logic [FW-1:0] m_prev [NF];
    logic [FW-1:0] m_ld   [NF];
    logic [7:0]    m_stat;
    logic [NF-1:0] m_flags;
    logic          m_req;
    int            m_cnt;
    logic          m_phase;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NF; i++) live_time[i*FW +: FW] = live[i];
    end

    tsnap_ctrl #(.FIELD_W(FW), .NUM_FIELDS(NF), .ADDR_W(AW), .HALF_CYC(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_snap(cmd_snap), .cmd_load(cmd_load),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .live_time(live_time),
        .host_sel_n(host_sel_n), .stat_reg(stat_reg), .flag_reg(flag_reg),
        .snap_regs(snap_regs), .load_req(load_req), .load_time(load_time),
        .meas_out(meas_out)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural update of the model at one rising edge, from the applied inputs.
    task automatic model_edge();
        if (!rst_n) begin
            for (int i = 0; i < NF; i++) begin
                m_snap[i] = '0; m_prev[i] = '0; m_ld[i] = '0;
            end
            m_stat = '0; m_flags = '0; m_req = 1'b0; m_cnt = 0; m_phase = 1'b0;
        end else begin
            m_req = 1'b0;
            if (cmd_snap) begin
                for (int i = 0; i < NF; i++) begin
                    m_flags[i] = (live[i] != m_prev[i]);
                    m_prev[i]  = live[i];
                    m_snap[i]  = live[i];
                end
            end else begin
                if (cmd_load && !m_stat[4]) begin
                    m_req = 1'b1;
                    m_flags = '0;
                    for (int i = 0; i < NF; i++) m_ld[i] = m_snap[i];
                end
                if (wr_en && wr_addr >= 2 && wr_addr <= 9) m_snap[wr_addr-2] = wr_data;
            end
            if (wr_en && wr_addr == 0) begin
                m_stat = 8'h00;
                m_stat[0] = wr_data[0];
                m_stat[2] = wr_data[2];
                m_stat[3] = wr_data[3];
                m_stat[4] = wr_data[4];
            end
            if (m_cnt == HALF - 1) begin
                m_cnt = 0;
                m_phase = ~m_phase;
            end else begin
                m_cnt++;
            end
        end
    endtask

    task automatic compare();
        logic [63:0] es, el;
        es = '0; el = '0;
        for (int i = 0; i < NF; i++) begin
            es[i*FW +: FW] = m_snap[i];
            el[i*FW +: FW] = m_ld[i];
        end
        chk("R1 R7 R10 snapshot registers", snap_regs, es);
        chk("R2 R3 R4 R5 change flags", flag_reg, m_flags);
        chk("R6 status register", stat_reg, m_stat);
        chk("R3 R4 load request", load_req, m_req);
        chk("R3 load time", load_time, el);
        chk("R8 measurement output", meas_out, m_stat[0] & host_sel_n & m_phase);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #2;
        compare();
    endtask

    task automatic do_snap();
        cmd_snap = 1'b1; step(); cmd_snap = 1'b0;
    endtask

    task automatic do_load();
        cmd_load = 1'b1; step(); cmd_load = 1'b0;
    endtask

    task automatic do_wr(input int a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; step(); wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NF; i++) live[i] = 8'h55;
        rst_n = 1'b0;
        idle(3);
        // R9: everything cleared by reset
        chk("R9 reset status", stat_reg, 0);
        chk("R9 reset flags", flag_reg, 0);
        chk("R9 reset snapshot", snap_regs, 0);
        chk("R9 reset load request", load_req, 0);
        chk("R9 reset meas", meas_out, 0);
        rst_n = 1'b1;
        idle(2);

        live[0] = 8'h30; live[1] = 8'h15; live[2] = 8'h09; live[3] = 8'h21;
        live[4] = 8'h04; live[5] = 8'h24; live[6] = 8'h03; live[7] = 8'h16;
        do_snap();
        chk("R2 first snapshot flags", flag_reg, 8'hFF);
        chk("R1 seconds captured", snap_regs[7:0], 8'h30);

        live[0] = 8'h31; live[1] = 8'h16;
        do_snap();
        chk("R2 seconds and minutes changed", flag_reg, 8'h03);
        do_snap();
        chk("R2 nothing changed", flag_reg, 8'h00);

        do_wr(2, 8'h99);
        chk("R7 field write", snap_regs[7:0], 8'h99);
        live[3] = 8'h45;
        idle(3);
        chk("R10 hold while live moves", snap_regs[7:0], 8'h99);
        live[3] = 8'h21;
        do_snap();
        chk("R2 host write does not disturb compare", flag_reg, 8'h00);

        live[7] = 8'h17;
        do_snap();
        chk("R2 week number changed", flag_reg, 8'h80);
        do_wr(9, 8'h42);
        do_load();
        chk("R3 load clears flags", flag_reg, 8'h00);
        chk("R3 load request", load_req, 1'b1);
        chk("R3 load week number", load_time[63:56], 8'h42);
        step();
        chk("R3 request is one cycle", load_req, 1'b0);

        do_wr(0, 8'h10);
        live[5] = 8'h25;
        do_snap();
        do_load();
        chk("R4 locked load ignored", load_req, 1'b0);
        chk("R4 flags kept under lock", flag_reg, 8'h20);
        do_wr(1, 8'h00);
        chk("R5 flag register read-only", flag_reg, 8'h20);
        do_wr(0, 8'hFF);
        chk("R6 reserved bits zero", stat_reg, 8'h1D);
        do_wr(0, 8'h01);
        do_load();
        chk("R4 unlock re-enables load", load_req, 1'b1);

        host_sel_n = 1'b1;
        idle(30);
        host_sel_n = 1'b0;
        idle(7);
        host_sel_n = 1'b1;
        idle(12);
        do_wr(12, 8'hAA);
        do_wr(15, 8'hAA);

        // snapshot and field write together: snapshot wins (R7)
        live[0] = 8'h07;
        cmd_snap = 1'b1; wr_en = 1'b1; wr_addr = 4'd2; wr_data = 8'hEE;
        step();
        cmd_snap = 1'b0; wr_en = 1'b0;
        chk("R7 snapshot beats field write", snap_regs[7:0], 8'h07);

        for (int n = 0; n < 600; n++) begin
            cmd_snap   = ($urandom_range(7) == 0);
            cmd_load   = ($urandom_range(5) == 0);
            wr_en      = ($urandom_range(2) == 0);
            wr_addr    = AW'($urandom_range(15));
            wr_data    = 8'($urandom);
            if (wr_addr == 0) wr_data[4] = ($urandom_range(2) == 0);
            if ($urandom_range(3) == 0) live[$urandom_range(NF-1)] = 8'($urandom);
            if ($urandom_range(9) == 0) host_sel_n = ~host_sel_n;
            rst_n = (n != 300);
            step();
        end
        cmd_snap = 1'b0; cmd_load = 1'b0; wr_en = 1'b0; rst_n = 1'b1;
        idle(4);
        finish_run();
    end
endmodule